// File: doc/BRIEF.md
# Two-Label Binary Region Labeler

This block segments a small binary image into 4-connected regions and labels both colours in the same run: a run of zeros is a region just as much as a run of ones. Every pixel ends with two labels. The first is a root label, the raster position plus one of one pixel chosen as that region's seed. The second is the total number of pixels in the region. Root labels tell regions apart. Size labels can repeat, because two regions may have the same size.

The host first writes the image one bit at a time through a pixel write port, then pulses `start`. The block then runs these steps in order:

1. It sets every pixel as its own singleton, with size one.
2. It sweeps every left-neighbour pair in raster order, then every upper-neighbour pair in raster order. Whenever the two bits of a pair are equal, it finds both roots one hop per cycle and hangs the later pixel's root under the earlier pixel's root, adding the sizes.
3. A final raster sweep follows each pixel's label chain to its fixed point and writes the root and the root's size into that pixel.

When `done` rises, the results can be read combinationally by address.

Top module: `region_labeler`

## Requirements
- R1: A one-cycle `start` in the idle or finished state begins a run. `done` is low on the cycle after `start` and through the run. It rises when the last pixel is resolved and stays high until the next `start`.
- R2: A pixel whose bit differs from all of its 4-neighbours reads back label = row*WIDTH+col+1 and size 1. In a checkerboard this holds for every pixel.
- R3: Two pixels that are left/right or up/down neighbours with equal bits, whether both 0 or both 1, read back the same label.
- R4: Pixels of equal value that touch only at a corner, and are not joined by any 4-connected path, read back different labels.
- R5: Every label L lies in 1..WIDTH*HEIGHT and names pixel L-1, which lies in the same region and reads back label L itself. Distinct regions therefore carry distinct labels.
- R6: Every pixel's size equals the pixel count of its 4-connected equal-valued region. A uniform image gives WIDTH*HEIGHT at every pixel.
- R7: Pixel writes are ignored while a run is in progress. A later `start` without reloading reprocesses the stored image from fresh singleton labels and gives the same result.
- R8: Long winding regions whose label chains are several hops deep still resolve to one common root with the full size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a labeling run |
| pixWe | input | 1 | Pixel bit write enable, honoured only when not running |
| pixAddr | input | AW | Raster address of the written pixel (row*WIDTH+col) |
| pixBit | input | 1 | Binary value written to the pixel |
| rdAddr | input | AW | Raster address of the result to read |
| rdLabel | output | LW | Root label of the addressed pixel (1-based raster position of its seed) |
| rdSize | output | LW | Pixel count of the addressed pixel's region |
| done | output | 1 | High from the end of a run until the next start |

## Verification
The bench builds the block with WIDTH=8 and HEIGHT=6. This is a non-square image of 48 pixels, which is not a power of two. A swap of row and column stepping, or a wrong upper-neighbour offset, therefore shows up as a wrong region instead of cancelling out. The small image lets every run be compared in full against a flood-fill reference computed in the bench. That makes random images cheap alongside the directed shapes. It also puts within a few hundred cycles the winding, U-shaped and corner-touching layouts where one root gets hung under another.

// File: rtl/rlab_pkg.sv
package rlab_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_CMP,
    ST_FINDA,
    ST_FINDB,
    ST_FSTART,
    ST_FFIND,
    ST_DONE
  } rlab_state_e;

  // Strobes from the sequencer to the datapath, one bit per action.
  typedef struct packed {
    logic initAll;
    logic walkFromNbr;
    logic walkFromPos;
    logic stepWalk;
    logic latchRoot;
    logic doUnion;
    logic flatWrite;
  } rlab_strobe_t;

endpackage

// File: rtl/region_label_ctrl.sv
module region_label_ctrl
  import rlab_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int HEIGHT = 16,
  localparam int NPIX = WIDTH * HEIGHT,
  localparam int AW   = $clog2(NPIX),
  localparam int CW   = $clog2(WIDTH),
  localparam int RW   = $clog2(HEIGHT)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         pixEqual,
  input  logic         walkIsRoot,
  input  logic         rootsEqual,
  output rlab_strobe_t cs,
  output logic [AW-1:0] posIdx,
  output logic [AW-1:0] nbrIdx,
  output logic         busy,
  output logic         done
);

  rlab_state_e state, stNext;
  logic [AW-1:0] pos, posNext;
  logic [CW-1:0] col, colNext;
  logic [RW-1:0] row, rowNext;
  logic          vert, vertNext;
  logic          lastPix, pairValid, doAdvance;

  assign lastPix   = (pos == AW'(NPIX - 1));
  assign pairValid = vert ? (row != '0) : (col != '0);
  assign posIdx    = pos;
  assign nbrIdx    = vert ? (pos - AW'(WIDTH)) : (pos - AW'(1));
  assign done      = (state == ST_DONE);
  assign busy      = (state != ST_IDLE) && (state != ST_DONE);

  always_comb begin
    stNext    = state;
    posNext   = pos;
    colNext   = col;
    rowNext   = row;
    vertNext  = vert;
    cs        = '0;
    doAdvance = 1'b0;
    case (state)
      ST_IDLE, ST_DONE: begin
        if (start) stNext = ST_INIT;
      end
      ST_INIT: begin
        cs.initAll = 1'b1;
        posNext    = '0;
        colNext    = '0;
        rowNext    = '0;
        vertNext   = 1'b0;
        stNext     = ST_CMP;
      end
      ST_CMP: begin
        if (pairValid && pixEqual) begin
          cs.walkFromNbr = 1'b1;
          stNext         = ST_FINDA;
        end else begin
          doAdvance = 1'b1;
        end
      end
      ST_FINDA: begin
        if (walkIsRoot) begin
          cs.latchRoot   = 1'b1;
          cs.walkFromPos = 1'b1;
          stNext         = ST_FINDB;
        end else begin
          cs.stepWalk = 1'b1;
        end
      end
      ST_FINDB: begin
        if (walkIsRoot) begin
          cs.doUnion = !rootsEqual;
          doAdvance  = 1'b1;
        end else begin
          cs.stepWalk = 1'b1;
        end
      end
      ST_FSTART: begin
        cs.walkFromPos = 1'b1;
        stNext         = ST_FFIND;
      end
      ST_FFIND: begin
        if (walkIsRoot) begin
          cs.flatWrite = 1'b1;
          if (lastPix) begin
            stNext = ST_DONE;
          end else begin
            posNext = pos + AW'(1);
            stNext  = ST_FSTART;
          end
        end else begin
          cs.stepWalk = 1'b1;
        end
      end
      default: stNext = ST_IDLE;
    endcase

    if (doAdvance) begin
      if (lastPix) begin
        posNext = '0;
        colNext = '0;
        rowNext = '0;
        if (vert) begin
          stNext = ST_FSTART;
        end else begin
          vertNext = 1'b1;
          stNext   = ST_CMP;
        end
      end else begin
        posNext = pos + AW'(1);
        stNext  = ST_CMP;
        if (col == CW'(WIDTH - 1)) begin
          colNext = '0;
          rowNext = row + RW'(1);
        end else begin
          colNext = col + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      pos   <= '0;
      col   <= '0;
      row   <= '0;
      vert  <= 1'b0;
    end else begin
      state <= stNext;
      pos   <= posNext;
      col   <= colNext;
      row   <= rowNext;
      vert  <= vertNext;
    end
  end

  // R1: a start pulse always clears done on the following cycle
  p_start_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !done);

  // R1: done is held until a new start arrives
  p_done_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

endmodule

// File: rtl/region_label_dp.sv
module region_label_dp
  import rlab_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int HEIGHT = 16,
  localparam int NPIX = WIDTH * HEIGHT,
  localparam int AW   = $clog2(NPIX),
  localparam int LW   = $clog2(NPIX + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  rlab_strobe_t  cs,
  input  logic          busy,
  input  logic [AW-1:0] posIdx,
  input  logic [AW-1:0] nbrIdx,
  input  logic          pixWe,
  input  logic [AW-1:0] pixAddr,
  input  logic          pixBit,
  input  logic [AW-1:0] rdAddr,
  output logic          pixEqual,
  output logic          walkIsRoot,
  output logic          rootsEqual,
  output logic [LW-1:0] rdLabel,
  output logic [LW-1:0] rdSize
);

  logic [NPIX-1:0] pixBits;
  logic [LW-1:0]   labelMem [NPIX];
  logic [LW-1:0]   sizeMem  [NPIX];
  logic [LW-1:0]   walk;
  logic [LW-1:0]   rootA;

  logic [AW-1:0] walkIdx, rootIdx;
  logic [LW-1:0] posLabel, nbrLabel, rootSize;
  logic          rootSelf;

  assign walkIdx  = AW'(walk - LW'(1));
  assign rootIdx  = AW'(rootA - LW'(1));
  assign posLabel = LW'(posIdx) + LW'(1);
  assign nbrLabel = LW'(nbrIdx) + LW'(1);
  assign rootSize = sizeMem[rootIdx];
  assign rootSelf = (labelMem[rootIdx] == rootA);

  assign pixEqual   = (pixBits[posIdx] == pixBits[nbrIdx]);
  assign walkIsRoot = (labelMem[walkIdx] == walk);
  assign rootsEqual = (walk == rootA);

  assign rdLabel = labelMem[rdAddr];
  assign rdSize  = sizeMem[rdAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixBits <= '0;
      walk    <= LW'(1);
      rootA   <= LW'(1);
      for (int i = 0; i < NPIX; i++) begin
        labelMem[i] <= LW'(i + 1);
        sizeMem[i]  <= LW'(1);
      end
    end else begin
      if (pixWe && !busy) pixBits[pixAddr] <= pixBit;

      if (cs.initAll) begin
        for (int i = 0; i < NPIX; i++) begin
          labelMem[i] <= LW'(i + 1);
          sizeMem[i]  <= LW'(1);
        end
      end

      if (cs.walkFromNbr) walk <= nbrLabel;
      if (cs.walkFromPos) walk <= posLabel;
      if (cs.stepWalk)    walk <= labelMem[walkIdx];
      if (cs.latchRoot)   rootA <= walk;

      // Later root joins the earlier root; the earlier root absorbs its size.
      if (cs.doUnion) begin
        labelMem[walkIdx] <= rootA;
        sizeMem[rootIdx]  <= sizeMem[rootIdx] + sizeMem[walkIdx];
      end

      if (cs.flatWrite) begin
        labelMem[posIdx] <= walk;
        sizeMem[posIdx]  <= sizeMem[walkIdx];
      end
    end
  end

  // R7: the stored image cannot change while a run is in progress
  p_pix_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(pixBits));

  // R5: the chain walker only ever points at a legal pixel label
  p_walk_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    (walk != '0) && (int'(walk) <= NPIX));

  // R3: a union only ever attaches to a region root
  p_union_root_r3: assert property (@(posedge clk) disable iff (!rstN)
    cs.doUnion |-> rootSelf);

  // R6: a union strictly grows the surviving region
  p_size_grow_r6: assert property (@(posedge clk) disable iff (!rstN)
    cs.doUnion |=> (rootSize > $past(rootSize)));

  // R6: no region is counted larger than the image
  p_size_cap_r6: assert property (@(posedge clk) disable iff (!rstN)
    int'(rootSize) <= NPIX);

endmodule

// File: rtl/region_labeler.sv
module region_labeler
  import rlab_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int HEIGHT = 16,
  localparam int NPIX = WIDTH * HEIGHT,
  localparam int AW   = $clog2(NPIX),
  localparam int LW   = $clog2(NPIX + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          pixWe,
  input  logic [AW-1:0] pixAddr,
  input  logic          pixBit,
  input  logic [AW-1:0] rdAddr,
  output logic [LW-1:0] rdLabel,
  output logic [LW-1:0] rdSize,
  output logic          done
);

  rlab_strobe_t  cs;
  logic [AW-1:0] posIdx, nbrIdx;
  logic          busy, pixEqual, walkIsRoot, rootsEqual;

  region_label_ctrl #(.WIDTH(WIDTH), .HEIGHT(HEIGHT)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .pixEqual   (pixEqual),
    .walkIsRoot (walkIsRoot),
    .rootsEqual (rootsEqual),
    .cs         (cs),
    .posIdx     (posIdx),
    .nbrIdx     (nbrIdx),
    .busy       (busy),
    .done       (done)
  );

  region_label_dp #(.WIDTH(WIDTH), .HEIGHT(HEIGHT)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cs         (cs),
    .busy       (busy),
    .posIdx     (posIdx),
    .nbrIdx     (nbrIdx),
    .pixWe      (pixWe),
    .pixAddr    (pixAddr),
    .pixBit     (pixBit),
    .rdAddr     (rdAddr),
    .pixEqual   (pixEqual),
    .walkIsRoot (walkIsRoot),
    .rootsEqual (rootsEqual),
    .rdLabel    (rdLabel),
    .rdSize     (rdSize)
  );

endmodule

// File: tb/tb_region_labeler.sv
module tb_region_labeler;

  localparam int W    = 8;
  localparam int H    = 6;
  localparam int NPIX = W * H;
  localparam int AW   = $clog2(NPIX);
  localparam int LW   = $clog2(NPIX + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          pixWe = 1'b0;
  logic [AW-1:0] pixAddr = '0;
  logic          pixBit = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic [LW-1:0] rdLabel, rdSize;
  logic          done;

  int total = 0;
  int bad   = 0;

  bit img    [NPIX];
  int refReg [NPIX];
  int refCnt [NPIX];
  int gotL   [NPIX];
  int gotS   [NPIX];

  always #2 clk = ~clk;

  region_labeler #(.WIDTH(W), .HEIGHT(H)) dut (
    .clk(clk), .rstN(rstN), .start(start), .pixWe(pixWe), .pixAddr(pixAddr),
    .pixBit(pixBit), .rdAddr(rdAddr), .rdLabel(rdLabel), .rdSize(rdSize), .done(done)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic loadImage();
    for (int p = 0; p < NPIX; p++) begin
      @(negedge clk);
      pixWe = 1'b1; pixAddr = AW'(p); pixBit = img[p];
    end
    @(negedge clk);
    pixWe = 1'b0;
  endtask

  // Start a run; check done drops and later rises and holds (R1).
  task automatic runOnce(bit flipDuring);
    int cyc;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(done == 1'b0, "R1", "done low after start", done, 0);
    if (flipDuring) begin
      for (int p = 0; p < NPIX; p++) begin
        pixWe = 1'b1; pixAddr = AW'(p); pixBit = ~img[p];
        @(negedge clk);
      end
      pixWe = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk); cyc++;
    end
    check(done == 1'b1, "R1", "done reached", done, 1);
    repeat (3) @(negedge clk);
    check(done == 1'b1, "R1", "done held", done, 1);
  endtask

  task automatic readAll();
    for (int p = 0; p < NPIX; p++) begin
      rdAddr = AW'(p); #1;
      gotL[p] = int'(rdLabel); gotS[p] = int'(rdSize);
    end
  endtask

  function automatic void buildRef();
    bit changed;
    for (int p = 0; p < NPIX; p++) begin refReg[p] = p; refCnt[p] = 0; end
    do begin
      changed = 0;
      for (int p = 0; p < NPIX; p++) begin
        int r = p / W; int c = p % W;
        int nb [4]; int n = 0;
        if (c > 0) begin nb[n] = p - 1; n++; end
        if (c < W - 1) begin nb[n] = p + 1; n++; end
        if (r > 0) begin nb[n] = p - W; n++; end
        if (r < H - 1) begin nb[n] = p + W; n++; end
        for (int k = 0; k < n; k++)
          if (img[nb[k]] == img[p] && refReg[nb[k]] < refReg[p]) begin
            refReg[p] = refReg[nb[k]]; changed = 1;
          end
      end
    end while (changed);
    for (int p = 0; p < NPIX; p++) refCnt[refReg[p]]++;
  endfunction

  // Full comparison against the flood-fill reference.
  task automatic checkAll(string name);
    int e3a = 0, e3x = 0, e5a = -1, e5x = -1, e6a = -1, e6x = -1;
    bit ok3 = 1, ok5 = 1, ok6 = 1;
    buildRef();
    readAll();
    for (int p = 0; p < NPIX; p++) begin
      int L = gotL[p];
      if (ok6 && gotS[p] != refCnt[refReg[p]]) begin
        ok6 = 0; e6a = gotS[p]; e6x = refCnt[refReg[p]];
      end
      if (ok3 && (p % W) < W - 1 && img[p] == img[p + 1] && gotL[p] != gotL[p + 1]) begin
        ok3 = 0; e3a = gotL[p + 1]; e3x = gotL[p];
      end
      if (ok3 && p + W < NPIX && img[p] == img[p + W] && gotL[p] != gotL[p + W]) begin
        ok3 = 0; e3a = gotL[p + W]; e3x = gotL[p];
      end
      if (ok5) begin
        if (L < 1 || L > NPIX) begin
          ok5 = 0; e5a = L; e5x = p + 1;
        end else if (refReg[L - 1] != refReg[p] || gotL[L - 1] != L) begin
          ok5 = 0; e5a = gotL[L - 1]; e5x = L;
        end
      end
    end
    check(ok6, "R6", {name, " region sizes"}, e6a, e6x);
    check(ok3, "R3", {name, " 4-neighbours share label"}, e3a, e3x);
    check(ok5, "R5", {name, " label names own root"}, e5a, e5x);
  endtask

  task automatic t_reset();
    check(done == 1'b0, "R1", "done low after reset", done, 0);
  endtask

  task automatic t_checker();
    bit ok = 1; int a = 0, x = 0;
    for (int p = 0; p < NPIX; p++) img[p] = bit'(((p / W) + (p % W)) % 2);
    loadImage(); runOnce(0); checkAll("checker");
    for (int p = 0; p < NPIX; p++)
      if (ok && (gotL[p] != p + 1 || gotS[p] != 1)) begin ok = 0; a = gotL[p]; x = p + 1; end
    check(ok, "R2", "checkerboard singleton labels", a, x);
  endtask

  task automatic t_uniform(bit v);
    for (int p = 0; p < NPIX; p++) img[p] = v;
    loadImage(); runOnce(0); checkAll("uniform");
    check(gotS[NPIX - 1] == NPIX, "R6", "uniform size", gotS[NPIX - 1], NPIX);
    check(gotL[NPIX - 1] == gotL[0], "R3", "uniform single label", gotL[NPIX - 1], gotL[0]);
  endtask

  task automatic t_stripes();
    for (int p = 0; p < NPIX; p++) img[p] = bit'((p % W) % 2 == 0);
    loadImage(); runOnce(0); checkAll("stripes");
    check(gotS[0] == H, "R3", "column stripe size", gotS[0], H);
  endtask

  task automatic t_diagonal();
    for (int p = 0; p < NPIX; p++) img[p] = 1'b0;
    img[0] = 1'b1; img[W + 1] = 1'b1;
    loadImage(); runOnce(0); checkAll("diagonal");
    check(gotL[0] != gotL[W + 1], "R4", "corner-only pixels separate", gotL[W + 1], 1);
    check(gotS[W + 1] == 1 && gotL[W + 1] == W + 2, "R2", "isolated pixel label", gotL[W + 1], W + 2);
  endtask

  task automatic t_serpentine();
    for (int p = 0; p < NPIX; p++) begin
      int r = p / W; int c = p % W;
      img[p] = bit'((r % 2 == 0) || (r % 4 == 1 && c == W - 1) || (r % 4 == 3 && c == 0));
    end
    loadImage(); runOnce(0); checkAll("serpentine");
    check(gotS[0] == 27, "R8", "winding region size", gotS[0], 27);
    check(gotL[NPIX - 1] == gotL[0], "R8", "winding region root", gotL[NPIX - 1], gotL[0]);
  endtask

  task automatic t_ushape();
    for (int p = 0; p < NPIX; p++) begin
      int r = p / W; int c = p % W;
      img[p] = bit'((r < 4 && (c == 1 || c == 5)) || (r == 4 && c >= 1 && c <= 5));
    end
    loadImage(); runOnce(0); checkAll("ushape");
    check(gotL[1] == gotL[5], "R3", "U arms joined", gotL[5], gotL[1]);
  endtask

  task automatic t_random(int dens);
    for (int p = 0; p < NPIX; p++) img[p] = bit'($urandom_range(99, 0) < dens);
    loadImage(); runOnce(0); checkAll("random");
  endtask

  task automatic t_busyWrite();
    for (int p = 0; p < NPIX; p++) img[p] = bit'($urandom_range(1, 0));
    loadImage(); runOnce(1); checkAll("R7 writes while running");
    runOnce(0); checkAll("R7 rerun stored image");
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL R1 watchdog expired: actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_checker();
    t_uniform(1'b1);
    t_uniform(1'b0);
    t_stripes();
    t_diagonal();
    t_serpentine();
    t_ushape();
    t_random(50);
    t_random(30);
    t_random(65);
    t_random(45);
    t_busyWrite();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule